// File: doc/BRIEF.md
# Tiny Teaching-ISA Processor Core

This block is a small multi-cycle processor for a 16-bit fixed-width teaching instruction set. It has sixteen general-purpose 16-bit registers, a three-bit flag register and a hardware return-address stack. Each instruction is fetched from a synchronous instruction memory and then executed. The memory port returns the word for `imem_addr` one clock after the address is presented. The core keeps that address steady for the whole of an instruction.

Data leaves and enters the core through two valid/ready streams. An IN instruction waits in its execute cycle with `in_ready` high until the producer raises `in_valid`. The word moves on the first edge where both are high. An OUT instruction holds `out_valid` high and `out_data` steady until the consumer raises `out_ready`. Neither side may drop a word: a stalled consumer or an absent producer simply freezes the core.

The core stops on four conditions: an opcode of 13 to 15, a conditional-branch condition code of 6 to 15, a CALL with the stack full, or a RET with the stack empty. When it stops, `fault` rises and stays high until reset. While halted, the core neither fetches nor handshakes.

Top module: `tiny_core`

## Requirements
- R1: After reset, `fault`, `out_valid` and `in_ready` are low, `imem_addr` is 0, and every register reads as zero.
- R2: An instruction that does not wait on a stream completes in two clocks, one to fetch and one to execute. A lone illegal word at address 0 raises `fault` on the second clock edge after reset is released.
- R3: Moves and immediate loads:
  - opcode 0 copies the register in bits 3:0 into the register in bits 7:4.
  - opcode 1 loads bits 7:0, zero-extended, into the register in bits 11:8.
  - opcode 9 changes nothing.
- R4: Opcodes 2 (add), 3 (subtract, first minus second) and 12 (multiply) write the low 16 bits of the result to the register in bits 11:8. The first operand comes from the register in bits 7:4 and the second from the register in bits 3:0.
- R5: Compare (opcode 4) computes the register in bits 7:4 minus the register in bits 3:0, writes no register, and sets the flags zero, negative and signed overflow. Conditions in bits 11:8 of opcode 5 are signed: 0 equal, 1 less, 2 greater, 3 less-or-equal, 4 greater-or-equal, 5 not-equal.
- R6: A taken conditional branch moves to its own address plus or minus bits 6:0, subtracting when bit 7 is set. A branch that is not taken continues at the next address.
- R7: Opcode 6 jumps to the 12-bit index in bits 11:0.
- R8: Opcode 7 pushes the next address onto a 16-entry stack and jumps to bits 11:0. Opcode 8 pops an address and continues there, so nested calls return in reverse order.
- R9: Opcode 10 writes `in_data` into the register in bits 3:0 on the edge where `in_valid` and `in_ready` are both high. It stalls with `in_ready` held high while `in_valid` is low.
- R10: Opcode 11 presents the register in bits 3:0 on `out_data` with `out_valid` high. Both stay unchanged until `out_ready` is high at an edge, and each word transfers exactly once.
- R11: A call with 16 entries already stacked, or a return with none, halts the core with `fault` high.
- R12: Opcodes 13 to 15, and condition codes 6 to 15, halt the core. Once halted, `fault` stays high, `imem_addr` is frozen, and `out_valid` and `in_ready` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 12 | Instruction index presented to the memory |
| imem_rdata | input | 16 | Instruction word, registered by the memory one clock after the address |
| in_valid | input | 1 | Producer has a word on `in_data` |
| in_ready | output | 1 | Core is executing IN and will take the word |
| in_data | input | 16 | Input stream word |
| out_valid | output | 1 | Core is executing OUT and `out_data` is valid |
| out_ready | input | 1 | Consumer takes `out_data` at this edge |
| out_data | output | 16 | Output stream word |
| fault | output | 1 | Sticky halt after an illegal encoding or a stack error |

## Verification
Register results are not visible at the ports, so every arithmetic, move and branch result is checked as the word an OUT instruction transfers. These checks compare the ordered list of captured stream words with values computed in the bench. Because of this they do not depend on how many cycles back-pressure adds.

Cycle-exact checks cover timing:
- A lone illegal word raises `fault` exactly two edges after reset is released.
- An OUT followed by an underflowing RET raises `fault` at the fourth edge with a consumer that is always ready.
- Once halted, `imem_addr` and the stream strobes are sampled at the falling edge over several cycles to confirm they are frozen.

Handshakes are sampled at the falling edge before the edge that completes them.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int ILEN = 16;
  localparam int PCW  = 12;
  localparam int FLDW = 4;

  localparam logic [3:0] OP_MOV  = 4'd0;
  localparam logic [3:0] OP_MOVI = 4'd1;
  localparam logic [3:0] OP_ADD  = 4'd2;
  localparam logic [3:0] OP_SUB  = 4'd3;
  localparam logic [3:0] OP_CMP  = 4'd4;
  localparam logic [3:0] OP_JCC  = 4'd5;
  localparam logic [3:0] OP_JMP  = 4'd6;
  localparam logic [3:0] OP_CALL = 4'd7;
  localparam logic [3:0] OP_RET  = 4'd8;
  localparam logic [3:0] OP_NOP  = 4'd9;
  localparam logic [3:0] OP_IN   = 4'd10;
  localparam logic [3:0] OP_OUT  = 4'd11;
  localparam logic [3:0] OP_MUL  = 4'd12;

  localparam logic [3:0] CC_EQ = 4'd0;
  localparam logic [3:0] CC_LT = 4'd1;
  localparam logic [3:0] CC_GT = 4'd2;
  localparam logic [3:0] CC_LE = 4'd3;
  localparam logic [3:0] CC_GE = 4'd4;
  localparam logic [3:0] CC_NE = 4'd5;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} state_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
  } flags_t;
endpackage

// File: rtl/tc_alu.sv
module tc_alu
  import tc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] result,
  output flags_t        cmp_flags
);
  logic [DW-1:0] sum, diff, prod;

  assign sum  = a + b;
  assign diff = a - b;
  assign prod = a * b;

  always_comb begin
    case (op)
      OP_ADD:  result = sum;
      OP_SUB:  result = diff;
      OP_MUL:  result = prod;
      default: result = '0;
    endcase
  end

  assign cmp_flags.z = (diff == '0);
  assign cmp_flags.n = diff[DW-1];
  assign cmp_flags.v = (a[DW-1] ^ b[DW-1]) & (diff[DW-1] ^ a[DW-1]);
endmodule

// File: rtl/tc_cond.sv
module tc_cond
  import tc_pkg::*;
(
  input  flags_t     flags,
  input  logic [3:0] cc,
  output logic       take,
  output logic       cc_ok
);
  logic lt;
  assign lt = flags.n ^ flags.v;

  always_comb begin
    cc_ok = 1'b1;
    case (cc)
      CC_EQ:   take = flags.z;
      CC_LT:   take = lt;
      CC_GT:   take = ~flags.z & ~lt;
      CC_LE:   take = flags.z | lt;
      CC_GE:   take = ~lt;
      CC_NE:   take = ~flags.z;
      default: begin
        take  = 1'b0;
        cc_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/tc_regfile.sv
module tc_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] ra,
  input  logic [$clog2(NREG)-1:0] rb,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [DW-1:0]           wd,
  output logic [DW-1:0]           rd_a,
  output logic [DW-1:0]           rd_b
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra];
  assign rd_b = regs[rb];
endmodule

// File: rtl/tc_retstack.sv
module tc_retstack #(
  parameter int DEPTH = 16,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] count;
  logic [IW-1:0] wr_idx, rd_idx;

  assign wr_idx = count[IW-1:0];
  assign rd_idx = count[IW-1:0] - IW'(1);
  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign top    = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (push) count <= count + CW'(1);
    else if (pop) count <= count - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= din;
  end

  a_r11_no_push_full: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  a_r11_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
  a_r8_one_op:        assert property (@(posedge clk) disable iff (!rst_n) !(push && pop));
  a_r8_count_bound:   assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH));
endmodule

// File: rtl/tiny_core.sv
module tiny_core
  import tc_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NREG     = 16,
  parameter int RS_DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [tc_pkg::PCW-1:0] imem_addr,
  input  logic [15:0]            imem_rdata,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [DW-1:0]          in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DW-1:0]          out_data,
  output logic                   fault
);
  state_e         state;
  logic [PCW-1:0] pc, pc_next, pc_inc, br_tgt, rs_top;
  flags_t         flags, cmp_flags;

  logic [3:0]    op, fd, fa, fb;
  logic [DW-1:0] rd_a, rd_b, alu_res, wdata;
  logic [3:0]    wa;
  logic          exec, take, cc_ok, rs_full, rs_empty;
  logic          bad_op, bad_cc, stk_err, fault_now, io_wait, fire, we, push, pop;

  assign op = imem_rdata[15:12];
  assign fd = imem_rdata[11:8];
  assign fa = imem_rdata[7:4];
  assign fb = imem_rdata[3:0];

  assign exec      = (state == ST_EXEC);
  assign bad_op    = (op > OP_MUL);
  assign bad_cc    = (op == OP_JCC) && !cc_ok;
  assign stk_err   = ((op == OP_CALL) && rs_full) || ((op == OP_RET) && rs_empty);
  assign fault_now = bad_op || bad_cc || stk_err;
  assign io_wait   = ((op == OP_IN) && !in_valid) || ((op == OP_OUT) && !out_ready);
  assign fire      = exec && !fault_now && !io_wait;

  assign in_ready  = exec && (op == OP_IN);
  assign out_valid = exec && (op == OP_OUT);
  assign out_data  = rd_b;
  assign imem_addr = pc;
  assign fault     = (state == ST_HALT);

  assign push = fire && (op == OP_CALL);
  assign pop  = fire && (op == OP_RET);

  assign pc_inc = pc + PCW'(1);
  assign br_tgt = imem_rdata[7] ? (pc - PCW'(imem_rdata[6:0])) : (pc + PCW'(imem_rdata[6:0]));

  always_comb begin
    case (op)
      OP_JMP, OP_CALL: pc_next = imem_rdata[PCW-1:0];
      OP_RET:          pc_next = rs_top;
      OP_JCC:          pc_next = take ? br_tgt : pc_inc;
      default:         pc_next = pc_inc;
    endcase
  end

  always_comb begin
    we = 1'b0;
    wa = fd;
    wdata = alu_res;
    case (op)
      OP_MOV: begin
        we = fire;
        wa = fa;
        wdata = rd_b;
      end
      OP_MOVI: begin
        we = fire;
        wdata = DW'(imem_rdata[7:0]);
      end
      OP_ADD, OP_SUB, OP_MUL: we = fire;
      OP_IN: begin
        we = fire;
        wa = fb;
        wdata = in_data;
      end
      default: we = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      pc    <= '0;
      flags <= '0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_EXEC;
        ST_EXEC: begin
          if (fault_now) begin
            state <= ST_HALT;
          end else if (fire) begin
            pc    <= pc_next;
            state <= ST_FETCH;
            if (op == OP_CMP) flags <= cmp_flags;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  tc_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra(fa), .rb(fb), .we(we), .wa(wa), .wd(wdata),
    .rd_a(rd_a), .rd_b(rd_b)
  );

  tc_alu #(.DW(DW)) u_alu (
    .op(op), .a(rd_a), .b(rd_b), .result(alu_res), .cmp_flags(cmp_flags)
  );

  tc_cond u_cond (
    .flags(flags), .cc(fd), .take(take), .cc_ok(cc_ok)
  );

  tc_retstack #(.DEPTH(RS_DEPTH), .W(PCW)) u_rs (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(pc_inc),
    .top(rs_top), .full(rs_full), .empty(rs_empty)
  );

  a_r12_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n) fault |=> fault);
  a_r12_halt_quiet:  assert property (@(posedge clk) disable iff (!rst_n) fault |-> (!out_valid && !in_ready));
  a_r12_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n) fault |=> $stable(imem_addr));
  a_r10_out_hold:    assert property (@(posedge clk) disable iff (!rst_n)
                       (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r9_in_wait:      assert property (@(posedge clk) disable iff (!rst_n) (in_ready && !in_valid) |=> in_ready);
  a_r2_addr_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
                       (state == ST_FETCH) |=> $stable(imem_addr));
endmodule

// File: tb/tiny_core_tb.sv
`timescale 1ns/1ps
module tiny_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] imem_addr;
  logic [15:0] imem_rdata = 16'h0;
  logic        in_valid, in_ready, out_valid, out_ready, fault;
  logic [15:0] in_data, out_data;

  always #5 clk = ~clk;

  tiny_core u_dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .fault(fault)
  );

  logic [15:0] mem [0:255];
  always @(posedge clk) imem_rdata <= mem[imem_addr[7:0]];

  int checks = 0, bad = 0;
  bit bp = 1'b0;
  int in_n = 0, in_idx = 0, out_cnt = 0, cyc = 0;
  logic [15:0] in_vals [0:255];
  logic [15:0] outs [0:511];
  logic xi, xo;
  logic [15:0] od;

  // stream driver and monitor: sample at negedge, act just after posedge
  initial begin
    in_valid = 1'b0;
    in_data = '0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      xi = in_valid && in_ready;
      xo = out_valid && out_ready;
      od = out_data;
      @(posedge clk);
      #1;
      cyc++;
      if (xo) begin
        if (out_cnt < 512) outs[out_cnt] = od;
        out_cnt++;
      end
      if (xi) in_idx++;
      if (in_idx >= in_n) in_valid = 1'b0;
      else if (!(in_valid && !xi)) in_valid = bp ? ((cyc % 3) != 1) : 1'b1;
      in_data = (in_idx < 256) ? in_vals[in_idx] : 16'h0;
      out_ready = bp ? ((cyc % 4) != 2) : 1'b1;
    end
  end

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'hD000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    in_idx = 0;
    out_cnt = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_fault(input int maxc, output int n);
    n = 0;
    while (!fault && n < maxc) begin
      @(posedge clk);
      #2;
      n++;
    end
  endtask

  task automatic wait_outs(input int target, input int maxc);
    int n = 0;
    while (out_cnt < target && n < maxc) begin
      @(posedge clk);
      #2;
      n++;
    end
  endtask

  function automatic logic [15:0] val_of(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h0002;
      3: return 16'h7FFF;
      4: return 16'h8000;
      5: return 16'hFFFF;
      6: return 16'h1234;
      default: return 16'h00FF;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] a, b, e;
    clear_mem();
    in_n = 0;

    // R1: reset state
    repeat (2) @(negedge clk);
    check_eq("R1 fault", fault, 0);
    check_eq("R1 addr", imem_addr, 0);
    check_eq("R1 out_valid", out_valid, 0);
    check_eq("R1 in_ready", in_ready, 0);

    // R3 R7 R1: moves, immediates, NOP, zero registers, absolute jump
    clear_mem();
    mem[0] = 16'h11A5; mem[1] = 16'h9000; mem[2] = 16'h0021; mem[3] = 16'hB002;
    mem[4] = 16'hB007; mem[5] = 16'h1FFF; mem[6] = 16'h000F; mem[7] = 16'hB000;
    mem[8] = 16'h60F0; mem[240] = 16'hB001;
    bp = 1'b0;
    do_reset();
    wait_fault(500, n);
    check_eq("R3 out count", out_cnt, 4);
    check_eq("R3 movi zero-extend via mov", outs[0], 16'h00A5);
    check_eq("R1 register reset value", outs[1], 16'h0000);
    check_eq("R3 mov into R0", outs[2], 16'h00FF);
    check_eq("R7 jump target", outs[3], 16'h00A5);

    // R4 R9 R10: arithmetic sweep through IN/OUT with back-pressure
    clear_mem();
    mem[0] = 16'hA001; mem[1] = 16'hA002; mem[2] = 16'h2312; mem[3] = 16'h3412;
    mem[4] = 16'hC512; mem[5] = 16'hB003; mem[6] = 16'hB004; mem[7] = 16'hB005;
    mem[8] = 16'h6000;
    for (int i = 0; i < 64; i++) begin
      in_vals[2*i] = val_of(i / 8);
      in_vals[2*i+1] = val_of(i % 8);
    end
    in_n = 128;
    bp = 1'b1;
    do_reset();
    wait_outs(192, 20000);
    check_eq("R9 all inputs consumed", in_idx, 128);
    check_eq("R10 output count", out_cnt, 192);
    for (int i = 0; i < 64; i++) begin
      a = val_of(i / 8);
      b = val_of(i % 8);
      e = a + b; check_eq("R4 add", outs[3*i], e);
      e = a - b; check_eq("R4 sub", outs[3*i+1], e);
      e = a * b; check_eq("R4 mul", outs[3*i+2], e);
    end
    check_eq("R9 no fault while stalled", fault, 0);

    // R5 R6: compare and all six conditions, signed
    clear_mem();
    mem[0] = 16'h1800; mem[1] = 16'h1901; mem[2] = 16'hA001; mem[3] = 16'hA002;
    mem[4] = 16'h4012;
    for (int c = 0; c < 6; c++) begin
      mem[5+4*c] = 16'h5003 | 16'(c << 8);
      mem[6+4*c] = 16'hB008;
      mem[7+4*c] = 16'h6000 | 16'(9 + 4*c);
      mem[8+4*c] = 16'hB009;
    end
    mem[29] = 16'h6002;
    in_n = 128;
    bp = 1'b0;
    do_reset();
    wait_outs(384, 60000);
    check_eq("R5 output count", out_cnt, 384);
    for (int i = 0; i < 64; i++) begin
      logic eq, lt;
      logic [5:0] exp;
      a = val_of(i / 8);
      b = val_of(i % 8);
      eq = (a == b);
      lt = ($signed(a) < $signed(b));
      exp = {!eq, !lt, eq || lt, !eq && !lt, lt, eq};
      for (int c = 0; c < 6; c++) check_eq("R5 R6 condition", outs[6*i+c], 16'(exp[c]));
    end

    // R6: backward sign-magnitude branch loop
    clear_mem();
    mem[0] = 16'h1105; mem[1] = 16'h1201; mem[2] = 16'h1300; mem[3] = 16'h3112;
    mem[4] = 16'hB001; mem[5] = 16'h4013; mem[6] = 16'h5583;
    in_n = 0;
    bp = 1'b1;
    do_reset();
    wait_fault(1000, n);
    check_eq("R6 loop count", out_cnt, 5);
    for (int i = 0; i < 5; i++) check_eq("R6 loop value", outs[i], 16'(4 - i));

    // R8: nested call and return
    clear_mem();
    mem[0] = 16'h1101; mem[1] = 16'h7005; mem[2] = 16'h1107; mem[3] = 16'hB001;
    mem[4] = 16'hE000; mem[5] = 16'h1102; mem[6] = 16'h7009; mem[7] = 16'hB001;
    mem[8] = 16'h8000; mem[9] = 16'hB001; mem[10] = 16'h1103; mem[11] = 16'h8000;
    do_reset();
    wait_fault(1000, n);
    check_eq("R8 out count", out_cnt, 3);
    check_eq("R8 inner", outs[0], 2);
    check_eq("R8 return to 7", outs[1], 3);
    check_eq("R8 return to 2", outs[2], 7);
    check_eq("R12 opcode 14 halts", fault, 1);

    // R11 R12: stack overflow, then halted core is frozen
    clear_mem();
    mem[0] = 16'hB000; mem[1] = 16'h7000;
    bp = 1'b0;
    do_reset();
    wait_fault(1000, n);
    check_eq("R11 overflow fault", fault, 1);
    check_eq("R11 calls before overflow", out_cnt, 17);
    @(negedge clk);
    a = 16'(imem_addr);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check_eq("R12 addr frozen", imem_addr, a);
      check_eq("R12 quiet strobes", {out_valid, in_ready, fault}, 3'b001);
    end

    // R11 R2: underflow timing with always-ready consumer
    clear_mem();
    mem[0] = 16'hB000; mem[1] = 16'h8000;
    do_reset();
    wait_fault(100, n);
    check_eq("R11 underflow fault", fault, 1);
    check_eq("R2 underflow edge count", n, 4);
    check_eq("R11 out before underflow", out_cnt, 1);

    // R12 R2: illegal conditions and opcodes, two-edge timing
    for (int c = 6; c < 16; c++) begin
      clear_mem();
      mem[0] = 16'h5001 | 16'(c << 8);
      do_reset();
      wait_fault(50, n);
      check_eq("R12 illegal condition edges", n, 2);
      check_eq("R12 illegal condition fault", fault, 1);
    end
    for (int o = 13; o < 16; o++) begin
      clear_mem();
      mem[0] = 16'(o << 12);
      do_reset();
      wait_fault(50, n);
      check_eq("R2 illegal opcode edges", n, 2);
      check_eq("R12 illegal opcode fault", fault, 1);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule